// File: doc/BRIEF.md
# Byte-wide memory to serial configuration loader

This block is the master end of a configuration chain. After a start pulse it generates its own configuration clock and addresses an external byte-wide memory. It takes one byte from the memory every eight configuration-clock periods and sends each byte out bit by bit on a single serial line, least significant bit first. Downstream devices in a daisy chain sample that line on the rising configuration-clock edge.

The configuration clock is the system clock divided down. Its rising and falling edges appear inside the block as one-cycle enables, so the whole design runs in one clock domain. A direction input, sampled at start, chooses whether the address counts up from 0x0000 or down from 0xFFFF. A byte count, also sampled at start, sets how many bytes are loaded. When that many bytes have left the serial line, the block stops its clock, holds the address, drives the serial line high and raises a done flag.

Top module: `prom_serial_loader`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `prom_addr` is 0x0000, `sdout` is 1, `done` is 0 and `cclk` is 0.
- R2: `cclk` toggles every `HALF_DIV` system clocks while loading and stays at 0 when not loading, so no configuration-clock edge happens outside a load.
- R3: A `start` pulse accepted outside a load samples `dir_down` and `byte_count`. With `dir_down`=0 the first byte is read from 0x0000. With `dir_down`=1 the first byte is read from 0xFFFF.
- R4: One byte of `prom_data` is captured on the first `cclk` rising edge of a load and on every eighth rising edge after it. The byte comes from the address present before that edge. `prom_addr` steps by one on that same edge: +1 when counting up, -1 when counting down, wrapping modulo 2^16.
- R5: The bits of each captured byte leave on `sdout` least significant bit first. Bit 0 of a byte captured on rising edge k is the value present at rising edge k+2, so it appears at the falling edge 1.5 periods after the capture.
- R6: `sdout` changes only in the system cycle in which `cclk` falls.
- R7: Successive bytes follow each other without idle bits. With N bytes, rising edges 2 to 8N+1 carry the stream. `sdout` is 1 at rising edges 0 and 1.
- R8: After the last bit, on the next falling edge, `done` rises and `sdout` goes to 1. From then on `cclk` stays low, `prom_addr` holds and `done` stays high until the next `start`.
- R9: A start with `byte_count`=0 raises `done` without producing any `cclk` rising edge.
- R10: A `start` pulse during a load is ignored. The address sequence, stream contents and byte count of the current load are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a load (one-cycle pulse) |
| dir_down | input | 1 | Address direction, sampled at start: 0 up, 1 down |
| byte_count | input | 16 | Number of bytes to load, sampled at start |
| prom_addr | output | 16 | Address to the external memory |
| prom_data | input | 8 | Data byte from the external memory |
| cclk | output | 1 | Generated configuration clock |
| sdout | output | 1 | Serial data to the chain, LSB first |
| done | output | 1 | Load finished |

## Verification
The bench goes after the 1.5-period latency. A design that emitted bit 0 one falling edge early or late would shift every bit of the stream by one position, and the stream check at rising edge 2 onward would catch it. A design that sent bytes MSB first would show a mismatch on the first byte whose bits differ. At byte boundaries the bench requires the next byte's bit 0 directly after the previous bit 7, so a design that left a gap or overlapped two bytes would fail. The down-counting load starts from 0xFFFF and must step down, so a wrong start value or a wrong step direction would show in the address check. The end of a load is checked for an exact number of rising edges, an address that holds afterwards, and a line held high. A zero-byte start must finish without any clock edge. A start pulse during a load must not restart the counter or change direction.

// File: rtl/prom_ld_pkg.sv
package prom_ld_pkg;
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_RUN  = 2'd1,
    LD_DONE = 2'd2
  } ld_state_e;
endpackage

// File: rtl/ld_cclk_gen.sv
module ld_cclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic cclk,
  output logic rise_en,
  output logic fall_en
);
  localparam int PW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(HALF_DIV - 1);

  logic [PW-1:0] ph_q;
  logic          cclk_q;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      ph_q   <= '0;
      cclk_q <= 1'b0;
    end else if (ph_q == PH_LAST) begin
      ph_q   <= '0;
      cclk_q <= ~cclk_q;
    end else begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign rise_en = en && (ph_q == PH_LAST) && !cclk_q;
  assign fall_en = en && (ph_q == PH_LAST) &&  cclk_q;
  assign cclk    = cclk_q;

  // R2: the two edge enables never fire together
  p_edges_excl_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rise_en, fall_en}));

  // R2: a rise enable is followed by a high clock
  p_rise_sets_r2: assert property (@(posedge clk) disable iff (rst)
    rise_en |=> cclk);
endmodule

// File: rtl/ld_addr_seq.sv
module ld_addr_seq #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              down,
  input  logic              step,
  input  logic              step_down,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
    end else if (load) begin
      addr_q <= down ? '1 : '0;
    end else if (step) begin
      addr_q <= step_down ? addr_q - 1'b1 : addr_q + 1'b1;
    end
  end

  assign addr = addr_q;

  // R3: a load places the address at one end of the range
  p_load_end_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> (addr == '0) || (addr == '1));
endmodule

// File: rtl/ld_serializer.sv
module ld_serializer #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] din,
  input  logic              fall_en,
  output logic              sdout,
  output logic              busy
);
  localparam int LW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [LW-1:0] LEFT_FULL = LW'(DATA_W - 1);

  logic [DATA_W-1:0] cap_q;
  logic [DATA_W-1:0] sh_q;
  logic [LW-1:0]     left_q;
  logic [1:0]        pend_q;
  logic              sdout_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_q   <= '0;
      sh_q    <= '0;
      left_q  <= '0;
      pend_q  <= 2'd0;
      sdout_q <= 1'b1;
    end else begin
      if (cap_en) begin
        cap_q  <= din;
        pend_q <= 2'd1;
      end
      if (fall_en) begin
        if (pend_q == 2'd2) begin
          sdout_q <= cap_q[0];
          sh_q    <= cap_q >> 1;
          left_q  <= LEFT_FULL;
          pend_q  <= 2'd0;
        end else begin
          if (pend_q == 2'd1) pend_q <= 2'd2;
          if (left_q != '0) begin
            sdout_q <= sh_q[0];
            sh_q    <= sh_q >> 1;
            left_q  <= left_q - 1'b1;
          end else begin
            sdout_q <= 1'b1;
          end
        end
      end
    end
  end

  assign sdout = sdout_q;
  assign busy  = (pend_q != 2'd0) || (left_q != '0);

  // R5: a byte is never captured while a previous one still waits to load
  p_no_overrun_r5: assert property (@(posedge clk) disable iff (rst)
    cap_en |-> (pend_q == 2'd0));
endmodule

// File: rtl/prom_serial_loader.sv
module prom_serial_loader
  import prom_ld_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 16,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              dir_down,
  input  logic [CNT_W-1:0]  byte_count,
  output logic [ADDR_W-1:0] prom_addr,
  input  logic [DATA_W-1:0] prom_data,
  output logic              cclk,
  output logic              sdout,
  output logic              done
);
  localparam int SW = (DATA_W > 2) ? $clog2(DATA_W) : 1;
  localparam logic [SW-1:0] SLOT_LAST = SW'(DATA_W - 1);

  ld_state_e        state_q;
  logic             dir_q;
  logic [CNT_W-1:0] total_q;
  logic [CNT_W-1:0] ncap_q;
  logic [SW-1:0]    slot_q;
  logic             done_q;

  logic rise_en, fall_en, ser_busy, cap_en, accept;

  assign accept = start && (state_q != LD_RUN);
  assign cap_en = (state_q == LD_RUN) && rise_en && (slot_q == '0) &&
                  (ncap_q != total_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LD_IDLE;
      dir_q   <= 1'b0;
      total_q <= '0;
      ncap_q  <= '0;
      slot_q  <= '0;
      done_q  <= 1'b0;
    end else if (accept) begin
      dir_q   <= dir_down;
      total_q <= byte_count;
      ncap_q  <= '0;
      slot_q  <= '0;
      done_q  <= (byte_count == '0);
      state_q <= (byte_count == '0) ? LD_DONE : LD_RUN;
    end else if (state_q == LD_RUN) begin
      if (rise_en) begin
        slot_q <= (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
        if (cap_en) ncap_q <= ncap_q + 1'b1;
      end
      if (fall_en && (ncap_q == total_q) && !ser_busy) begin
        state_q <= LD_DONE;
        done_q  <= 1'b1;
      end
    end
  end

  ld_cclk_gen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk(clk), .rst(rst), .en(state_q == LD_RUN),
    .cclk(cclk), .rise_en(rise_en), .fall_en(fall_en)
  );

  ld_addr_seq #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst(rst), .load(accept), .down(dir_down),
    .step(cap_en), .step_down(dir_q), .addr(prom_addr)
  );

  ld_serializer #(.DATA_W(DATA_W)) u_ser (
    .clk(clk), .rst(rst), .cap_en(cap_en), .din(prom_data),
    .fall_en(fall_en), .sdout(sdout), .busy(ser_busy)
  );

  assign done = done_q;

  // R6: the serial line moves only with a falling configuration edge
  p_sdout_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdout) |-> $past(fall_en));

  // R4: each capture moves the address by one in the sampled direction
  p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
    cap_en |=> prom_addr == ($past(dir_q) ? $past(prom_addr) - 1'b1
                                          : $past(prom_addr) + 1'b1));

  // R8: done persists until a new start
  p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  // R8: the line is high whenever done is set
  p_done_high_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> sdout);

  // R8: the address is frozen after completion
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == LD_DONE && !start) |=> $stable(prom_addr));

  // R2: no configuration edges outside a load
  p_no_edge_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q != LD_RUN) |-> (!rise_en && !fall_en));
endmodule

// File: tb/prom_serial_loader_tb.sv
module prom_serial_loader_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 16;

  logic              clk = 1'b0;
  logic              rst;
  logic              start;
  logic              dir_down;
  logic [CNT_W-1:0]  byte_count;
  logic [ADDR_W-1:0] prom_addr;
  logic [DATA_W-1:0] prom_data;
  logic              cclk, sdout, done;

  int n_checks = 0;
  int n_fails  = 0;
  int cycles   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prom_serial_loader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
                       .HALF_DIV(2)) dut_i (
    .clk(clk), .rst(rst), .start(start), .dir_down(dir_down),
    .byte_count(byte_count), .prom_addr(prom_addr), .prom_data(prom_data),
    .cclk(cclk), .sdout(sdout), .done(done)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  assign prom_data = mem_byte(prom_addr);

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard state
  bit          exp_q[$];
  bit          mon_on = 1'b0;
  int          rise_idx = 0;
  int          exp_n = 0;
  bit          exp_dir = 1'b0;
  logic [15:0] exp_start = 16'h0;
  logic        prev_cclk = 1'b0;
  logic        prev_sdout = 1'b1;

  function automatic logic [15:0] addr_after(input int k);
    return exp_dir ? exp_start - 16'(k) : exp_start + 16'(k);
  endfunction

  // monitor
  always @(negedge clk) begin
    cycles++;
    if (mon_on) begin
      if (sdout !== prev_sdout)
        check(prev_cclk && !cclk, "R6", "sdout moved off falling edge",
              cclk, 0);
      if (cclk && !prev_cclk) begin
        int caps;
        caps = rise_idx / 8 + 1;
        if (caps > exp_n) caps = exp_n;
        check(prom_addr == addr_after(caps), "R4", "address after rise",
              prom_addr, addr_after(caps));
        check(done == 1'b0, "R8", "done during load", done, 0);
        if (rise_idx < 2) begin
          check(sdout == 1'b1, "R7", "line before first bit", sdout, 1);
        end else if (exp_q.size() > 0) begin
          bit e;
          e = exp_q.pop_front();
          check(sdout == e, "R5", "stream bit", sdout, e);
        end else begin
          check(1'b0, "R7", "extra rising edge", rise_idx, 8*exp_n+2);
        end
        rise_idx++;
      end
    end
    prev_cclk  = cclk;
    prev_sdout = sdout;
  end

  // watchdog
  initial begin
    wait (cycles > 150000);
    check(1'b0, "R8", "watchdog expired", cycles, 0);
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  task automatic pulse_start(input bit d, input int n);
    @(negedge clk);
    dir_down   = d;
    byte_count = CNT_W'(n);
    start      = 1'b1;
    @(negedge clk);
    start      = 1'b0;
  endtask

  // driver: computes the expected stream and runs one load
  task automatic run_load(input bit d, input int n, input bit poke);
    int waited;
    exp_dir   = d;
    exp_n     = n;
    exp_start = d ? 16'hFFFF : 16'h0000;
    exp_q.delete();
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = mem_byte(addr_after(i));
      for (int j = 0; j < 8; j++) exp_q.push_back(b[j]);
    end
    rise_idx = 0;
    mon_on   = 1'b1;
    pulse_start(d, n);
    if (poke) begin
      repeat (40) @(negedge clk);
      pulse_start(!d, 7);   // R10: must be ignored
    end
    waited = 0;
    while (!done && waited < 20000) begin
      @(negedge clk);
      waited++;
    end
    check(done == 1'b1, "R8", "done reached", done, 1);
    check(rise_idx == ((n == 0) ? 0 : 8*n + 2), (n == 0) ? "R9" : "R7",
          "rising edge count", rise_idx, (n == 0) ? 0 : 8*n + 2);
    check(exp_q.size() == 0, poke ? "R10" : "R5", "bits left unsent",
          exp_q.size(), 0);
    check(sdout == 1'b1, "R8", "line high after load", sdout, 1);
    check(prom_addr == addr_after(n), "R3", "final address",
          prom_addr, addr_after(n));
    repeat (24) @(negedge clk);
    check(done == 1'b1 && cclk == 1'b0, "R8", "done held, clock stopped",
          {done, cclk}, 2);
    check(prom_addr == addr_after(n), "R8", "address held",
          prom_addr, addr_after(n));
    check(rise_idx == ((n == 0) ? 0 : 8*n + 2), "R2", "no edges after done",
          rise_idx, (n == 0) ? 0 : 8*n + 2);
    mon_on = 1'b0;
  endtask

  initial begin
    rst = 1'b1; start = 1'b0; dir_down = 1'b0; byte_count = '0;
    repeat (4) @(negedge clk);
    check(prom_addr == 16'h0 && sdout && !done && !cclk, "R1",
          "reset outputs", {prom_addr, sdout, done, cclk}, 16'h0 << 3 | 4);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(prom_addr == 16'h0 && sdout && !done && !cclk, "R1",
          "after reset", {prom_addr, sdout, done, cclk}, 4);
    repeat (10) @(negedge clk);
    check(cclk == 1'b0, "R2", "idle clock low", cclk, 0);

    run_load(1'b0, 3, 1'b0);   // R3 up from 0x0000
    run_load(1'b1, 4, 1'b0);   // R3 down from 0xFFFF
    run_load(1'b0, 1, 1'b0);   // single byte
    run_load(1'b0, 0, 1'b0);   // R9 empty load
    run_load(1'b1, 5, 1'b1);   // R10 start during load
    run_load(1'b0, 2, 1'b1);   // R10 again, other direction

    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule